// File: doc/BRIEF.md
# Reset Time-Out Sequencer

The block decides when the processor core may run after a reset or a wake-up. It keeps the core in reset while the power-on flag is low or the external reset pin is held low. On the first release after power-on it starts two timers together. The first is a power-up timer that counts slow reference ticks, 96 ticks by default. The second is an oscillator start-up counter that counts oscillator pulses, 1024 by default, and only counts pulses that arrive while the oscillator is flagged as valid. The core is released once every timer the event needs has finished. When two timers run, the release follows the later of the two.

The oscillator mode decides which timers run. The two crystal modes use the start-up counter and the two clocked modes do not. A wake-up from sleep in a crystal mode stalls the core for the start-up count only, and in a clocked mode it has no effect. An external reset after the power-up sequence has finished releases the core with no delay. The oscillator and the reference tick are single-cycle enable strobes in the block clock domain. Detecting the supply trip point and sensing oscillator amplitude are done outside the block.

Top module: `reset_timeout_seq`

## Requirements
- R1: `core_run` is 0 after `rst_n` and stays 0 on the clock edge after any cycle in which `por_ok` is 0 or `ext_rst_n` is 0.
- R2: In a crystal mode (`osc_mode` 2'b00 or 2'b01), the first release after power-on starts both timers on the edge that samples `por_ok` and `ext_rst_n` both 1. `core_run` rises one edge after the later of two events: the PWRT_TICKS-th sampled `ref_tick`, and the OST_CYCLES-th counted oscillator pulse.
- R3: In a clocked mode (`osc_mode` 2'b10 or 2'b11), the first release after power-on waits only for PWRT_TICKS ticks. `osc_pulse` and `osc_valid` play no part.
- R4: The start-up counter counts only edges where both `osc_pulse` and `osc_valid` are 1.
- R5: Once a power-up sequence has finished, a later release of `ext_rst_n` (with `por_ok` held at 1) raises `core_run` on the first edge that samples it high.
- R6: While `core_run` is 1 in a crystal mode, a sampled `wake_evt` clears `core_run` on that edge. `core_run` rises again one edge after the OST_CYCLES-th counted pulse, and `ref_tick` plays no part.
- R7: While `core_run` is 1 in a clocked mode, `wake_evt` has no effect and `core_run` stays 1.
- R8: A reset that arrives while timers are running discards their progress. On the next release the full sequence starts again from zero. If `por_ok` dropped, the whole power-up sequence also starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| por_ok | input | 1 | Supply above the power-on trip point |
| ext_rst_n | input | 1 | External reset pin, low holds the core in reset |
| wake_evt | input | 1 | Wake-up from sleep event, one cycle |
| osc_mode | input | 2 | 00/01 crystal modes, 10/11 clocked modes |
| osc_valid | input | 1 | Oscillator amplitude has reached valid levels |
| osc_pulse | input | 1 | One oscillator cycle has elapsed |
| ref_tick | input | 1 | Slow reference tick for the power-up timer |
| core_run | output | 1 | Core released from reset and not stalled |

## Verification
The bench measures the exact release edge in each case. It looks for a design that follows the wrong timer when the start-up count is longer than the power-up delay, and for one that follows the wrong timer when the power-up delay is longer. It starts `osc_valid` late, which exposes a counter that counts unqualified pulses by releasing about 300 cycles early. It checks that a wake-up in a clocked mode does not stall the core, and that a crystal wake-up does not wait on the power-up ticks. It interrupts a running sequence with a reset and checks that the release is measured from the new start, so a design that keeps its old count would release too soon.

// File: rtl/rtseq_pkg.sv
package rtseq_pkg;
  typedef enum logic [1:0] {
    SEQ_HOLD   = 2'd0,
    SEQ_TIMING = 2'd1,
    SEQ_RUN    = 2'd2
  } seq_state_t;

  // Crystal modes (00, 01) need the oscillator start-up count.
  function automatic logic needs_osc_wait(input logic [1:0] mode);
    return ~mode[1];
  endfunction

  // A timer that is not in use counts as finished.
  function automatic logic timer_ok(input logic used, input logic done);
    return ~used | done;
  endfunction
endpackage

// File: rtl/rtseq_counter.sv
module rtseq_counter #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clear)                cnt_q <= '0;
    else if (step && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIM);

  // R4
  hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(cnt_q));
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
endmodule

// File: rtl/rtseq_ctrl.sv
module rtseq_ctrl
  import rtseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       ext_rst_n,
  input  logic       wake_evt,
  input  logic [1:0] osc_mode,
  input  logic       pwrt_done,
  input  logic       ost_done,
  output logic       use_pwrt,
  output logic       use_ost,
  output logic       timers_clr,
  output logic       core_run
);
  seq_state_t state_q, state_d;
  logic pwr_done_q, pwr_done_d;
  logic use_pwrt_d, use_ost_d;
  logic hold_in, timers_ok;

  assign hold_in   = !por_ok || !ext_rst_n;
  assign timers_ok = timer_ok(use_pwrt, pwrt_done) && timer_ok(use_ost, ost_done);

  always_comb begin
    state_d    = state_q;
    pwr_done_d = pwr_done_q && por_ok;
    use_pwrt_d = use_pwrt;
    use_ost_d  = use_ost;
    if (hold_in) begin
      state_d = SEQ_HOLD;
    end else begin
      unique case (state_q)
        SEQ_HOLD: begin
          if (pwr_done_q) begin
            state_d = SEQ_RUN;
          end else begin
            state_d    = SEQ_TIMING;
            use_pwrt_d = 1'b1;
            use_ost_d  = needs_osc_wait(osc_mode);
          end
        end
        SEQ_TIMING: begin
          if (timers_ok) begin
            state_d    = SEQ_RUN;
            pwr_done_d = 1'b1;
          end
        end
        SEQ_RUN: begin
          if (wake_evt && needs_osc_wait(osc_mode)) begin
            state_d    = SEQ_TIMING;
            use_pwrt_d = 1'b0;
            use_ost_d  = 1'b1;
          end
        end
        default: state_d = SEQ_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_HOLD;
      pwr_done_q <= 1'b0;
      use_pwrt   <= 1'b0;
      use_ost    <= 1'b0;
    end else begin
      state_q    <= state_d;
      pwr_done_q <= pwr_done_d;
      use_pwrt   <= use_pwrt_d;
      use_ost    <= use_ost_d;
    end
  end

  assign timers_clr = (state_q != SEQ_TIMING);
  assign core_run   = (state_q == SEQ_RUN);

  // R1
  hold_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_in |=> !core_run);
  // R2
  wait_for_timers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_TIMING && !(pwrt_done || !use_pwrt)) |=> !core_run);
  // R7
  clocked_wake_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && wake_evt && osc_mode[1] && !hold_in) |=> core_run);
  // R6
  crystal_wake_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && wake_evt && !osc_mode[1]) |=> !core_run);
endmodule

// File: rtl/reset_timeout_seq.sv
module reset_timeout_seq #(
  parameter int OST_CYCLES = 1024,
  parameter int PWRT_TICKS = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       ext_rst_n,
  input  logic       wake_evt,
  input  logic [1:0] osc_mode,
  input  logic       osc_valid,
  input  logic       osc_pulse,
  input  logic       ref_tick,
  output logic       core_run
);
  logic use_pwrt, use_ost, timers_clr;
  logic pwrt_done, ost_done;
  logic pwrt_step, ost_step;

  assign pwrt_step = ref_tick && use_pwrt;
  assign ost_step  = osc_pulse && osc_valid && use_ost;

  rtseq_counter #(.LIMIT(PWRT_TICKS)) u_pwrt (
    .clk(clk), .rst_n(rst_n), .clear(timers_clr), .step(pwrt_step), .done(pwrt_done)
  );

  rtseq_counter #(.LIMIT(OST_CYCLES)) u_ost (
    .clk(clk), .rst_n(rst_n), .clear(timers_clr), .step(ost_step), .done(ost_done)
  );

  rtseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .ext_rst_n(ext_rst_n),
    .wake_evt(wake_evt), .osc_mode(osc_mode), .pwrt_done(pwrt_done),
    .ost_done(ost_done), .use_pwrt(use_pwrt), .use_ost(use_ost),
    .timers_clr(timers_clr), .core_run(core_run)
  );

  // R4
  gated_osc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_valid |-> !ost_step);
endmodule

// File: tb/reset_timeout_seq_test.sv
module reset_timeout_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int OSTN = 1024;
  localparam int PWRN = 40;

  logic clk = 0, rst_n = 0;
  logic por_ok = 0, ext_rst_n = 0, wake_evt = 0;
  logic [1:0] osc_mode = 2'b00;
  logic osc_valid = 0, osc_pulse = 0, ref_tick = 0;
  logic core_run;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_timeout_seq #(.OST_CYCLES(OSTN), .PWRT_TICKS(PWRN)) uut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .ext_rst_n(ext_rst_n),
    .wake_evt(wake_evt), .osc_mode(osc_mode), .osc_valid(osc_valid),
    .osc_pulse(osc_pulse), .ref_tick(ref_tick), .core_run(core_run)
  );

  int cyc = 0, p0 = 0, op = 1, tp = 8, vstart = 0;
  int n_checks = 0, n_fail = 0;
  bit done_flag = 0, prev_run = 0;
  int exp_q[$];
  string tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // stimulus pattern relative to the start edge p0
  always @(negedge clk) begin
    automatic int r = cyc + 1 - p0;
    osc_pulse <= (r > 0) && (r % op == 0);
    osc_valid <= (r >= vstart);
    ref_tick  <= (r > 0) && (r % tp == 0);
  end

  task automatic check(input string req, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // monitor: compare each release edge with the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if (core_run && !prev_run) begin
        if (exp_q.size() == 0) check("unexpected release", cyc, -1);
        else begin
          automatic int e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, cyc, e);
        end
      end
      prev_run = core_run;
    end
  end

  function automatic int ost_at(input int o, input int v);
    int cnt = 0;
    for (int r = 1; r < 100000; r++) begin
      if (r % o == 0 && r >= v) cnt++;
      if (cnt == OSTN) return r;
    end
    return -1;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic push_exp(input int e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic step_in();
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", core_run, 0);
    step_in(); rst_n = 1;
    step_in(); por_ok = 1;
    repeat (50) @(negedge clk);
    check("R1 pin held low", core_run, 0);

    // crystal power-up, start-up count longer than ticks
    osc_mode = 2'b00; op = 1; tp = 8; vstart = 0;
    step_in(); ext_rst_n = 1; p0 = cyc + 1;
    push_exp(p0 + max2(ost_at(1, 0), PWRN * 8) + 1, "R2 crystal power-up");
    wait_drain();

    // external reset after power-up: no delay
    step_in(); ext_rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 external reset", core_run, 0);
    repeat (5) @(negedge clk);
    step_in(); ext_rst_n = 1; p0 = cyc + 1;
    push_exp(p0, "R5 immediate release");
    wait_drain();

    // crystal wake: start-up only, ticks slow (would give 2000)
    tp = 50;
    step_in(); wake_evt = 1; p0 = cyc + 1;
    push_exp(p0 + ost_at(1, 0) + 1, "R6 crystal wake");
    step_in(); wake_evt = 0;
    @(negedge clk);
    check("R6 stall after wake", core_run, 0);
    wait_drain();

    // clocked-mode wake: no effect
    osc_mode = 2'b11;
    step_in(); wake_evt = 1;
    step_in(); wake_evt = 0;
    repeat (20) @(negedge clk);
    check("R7 clocked wake ignored", core_run, 1);

    // clocked-mode power-up: ticks only
    osc_mode = 2'b10; tp = 8; op = 1; vstart = 100000;
    step_in(); por_ok = 0;
    repeat (2) @(negedge clk);
    check("R1 por low", core_run, 0);
    repeat (3) @(negedge clk);
    step_in(); por_ok = 1; p0 = cyc + 1;
    push_exp(p0 + PWRN * 8 + 1, "R3 clocked power-up");
    wait_drain();

    // crystal power-up with the tick timer the longer one
    osc_mode = 2'b01; tp = 50; op = 1; vstart = 0;
    step_in(); por_ok = 0;
    repeat (4) @(negedge clk);
    step_in(); por_ok = 1; p0 = cyc + 1;
    push_exp(p0 + max2(ost_at(1, 0), PWRN * 50) + 1, "R2 ticks longer");
    wait_drain();

    // late oscillator valid, pulses every second cycle
    osc_mode = 2'b00; tp = 8; op = 2; vstart = 300;
    step_in(); por_ok = 0;
    repeat (4) @(negedge clk);
    step_in(); por_ok = 1; p0 = cyc + 1;
    push_exp(p0 + max2(ost_at(2, 300), PWRN * 8) + 1, "R4 valid gating");
    wait_drain();

    // reset in the middle of a running power-up sequence
    op = 1; vstart = 0;
    step_in(); por_ok = 0;
    repeat (4) @(negedge clk);
    step_in(); por_ok = 1; p0 = cyc + 1;
    repeat (600) @(negedge clk);
    check("R8 still timing", core_run, 0);
    step_in(); ext_rst_n = 0;
    repeat (10) @(negedge clk);
    check("R8 held during reset", core_run, 0);
    step_in(); ext_rst_n = 1; p0 = cyc + 1;
    push_exp(p0 + max2(ost_at(1, 0), PWRN * 8) + 1, "R8 restart from zero");
    wait_drain();
    check("R8 released", core_run, 1);

    finish_run();
  end
endmodule